// File: doc/BRIEF.md
# Key-Protected System Reset Controller

This block lets software in a small processor subsystem trigger a full reset by writing one 32-bit control word. The write counts only when its upper halfword holds a fixed unlock key, so a stray store cannot reset the system by accident. Low request bits choose what is reset: the processor core, the peripherals, both together, or only the board-level reset line. A small configuration field (an interrupt priority grouping) sits in the same word and is kept across the request write.

Once a request is accepted, the block runs a timed sequence. For a parameterised number of cycles it asserts the selected internal resets and pulls the open-drain external reset line low. It then waits to see that line low and afterwards released high before it reports completion. A status word shows a busy flag for the whole sequence. If a board fault holds the line high, the sequence stays in a wait state and keeps pulling until the line is finally seen low.

Top module: `key_reset_ctrl`

## Requirements
- R1: A write to word 0 with bits 31:16 equal to 0x05FA and bit 2 set starts a sequence that asserts `core_rst`, `periph_rst` and `pin_pull_low`.
- R2: A write to word 0 whose bits 31:16 differ from 0x05FA changes nothing: no sequence starts and the grouping field keeps its value.
- R3: A keyed write to word 0 stores bits 10:8 as the grouping field, and a keyed write that carries a request updates it in the same way. Word 0 reads back the field in bits 10:8.
- R4: Word 0 reads 0 in bits 31:16 and in the request bits 3:0.
- R5: Request bit 0 resets only the core, bit 1 only the peripherals, and bit 3 only the external line. These bits may be combined in one keyed write, and the line is pulled for any accepted request.
- R6: Status word 1, bit 0, reads 1 from the cycle after a request is accepted until the sequence completes, and 0 otherwise.
- R7: `core_rst` and `periph_rst` are asserted only while `pin_pull_low` is active. When the line follows the drive, the pull lasts exactly DELAY_CYC cycles.
- R8: If the sampled line stays high, the pull and the selected resets continue past DELAY_CYC. After the line is seen low and then high, the sequence completes.
- R9: Any write to word 0 while the status busy bit is 1 is ignored, both its requests and its grouping field.
- R10: After reset all outputs are 0, the busy bit is 0 and the grouping field is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 1 | Word select: 0 control, 1 status |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the selected word |
| core_rst | output | 1 | Active-high processor core reset |
| periph_rst | output | 1 | Active-high peripheral reset |
| pin_pull_low | output | 1 | 1 enables the open-drain pull-down on the external reset line |
| pin_level | input | 1 | Sampled level of the external reset line |

## Verification
Several properties are checked on every cycle. An internal reset is never active without the line pull, and the pull never runs outside the busy window. A pull starts only after an accepted request. Unkeyed writes, and writes made while busy, leave the grouping field alone. A stall state with the line still high keeps pulling. The bench scenarios are needed for the rest: the exact pulse length, which target each request bit selects, the readback layout, and recovery from a line stuck high. A scoreboard matches each observed pulse against the request that caused it.

// File: rtl/rstc_pkg.sv
package rstc_pkg;
  localparam logic [15:0] UNLOCK_KEY = 16'h05FA;
  localparam int KEY_LSB        = 16;
  localparam int REQ_CORE_BIT   = 0;
  localparam int REQ_PERIPH_BIT = 1;
  localparam int REQ_SYS_BIT    = 2;
  localparam int REQ_PIN_BIT    = 3;
  localparam int GRP_LSB        = 8;

  typedef struct packed {
    logic core;
    logic periph;
  } rst_targets_t;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_DELAY,
    SEQ_STALL,
    SEQ_RELEASE
  } seq_state_t;
endpackage

// File: rtl/rstc_regs.sv
module rstc_regs
  import rstc_pkg::*;
#(
  parameter int GRP_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_addr,
  input  logic [31:0]        reg_wdata,
  input  logic               busy,
  output logic [31:0]        reg_rdata,
  output logic               accept,
  output rst_targets_t       targets,
  output logic [GRP_W-1:0]   grp
);
  logic             key_ok;
  logic             ctrl_wr;
  logic             any_req;
  logic             grp_en;
  logic [GRP_W-1:0] grp_q, grp_d;
  logic [31:0]      ctrl_view;

  assign key_ok  = (reg_wdata[KEY_LSB +: 16] == UNLOCK_KEY);
  assign ctrl_wr = reg_wr && !reg_addr && key_ok && !busy;
  assign any_req = reg_wdata[REQ_CORE_BIT] | reg_wdata[REQ_PERIPH_BIT] |
                   reg_wdata[REQ_SYS_BIT]  | reg_wdata[REQ_PIN_BIT];

  assign accept         = ctrl_wr && any_req;
  assign targets.core   = reg_wdata[REQ_CORE_BIT]   | reg_wdata[REQ_SYS_BIT];
  assign targets.periph = reg_wdata[REQ_PERIPH_BIT] | reg_wdata[REQ_SYS_BIT];

  assign grp_en = ctrl_wr;
  assign grp_d  = reg_wdata[GRP_LSB +: GRP_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      grp_q <= '0;
    else if (grp_en) grp_q <= grp_d;
  end

  assign grp = grp_q;

  always_comb begin
    ctrl_view = '0;
    ctrl_view[GRP_LSB +: GRP_W] = grp_q;
  end

  assign reg_rdata = reg_addr ? {31'd0, busy} : ctrl_view;
endmodule

// File: rtl/rstc_sync.sv
module rstc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b1;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/rstc_seq.sv
module rstc_seq
  import rstc_pkg::*;
#(
  parameter int DELAY_CYC = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         accept,
  input  rst_targets_t targets,
  input  logic         pin_sync,
  output logic         busy,
  output logic         core_rst,
  output logic         periph_rst,
  output logic         pin_pull_low,
  output seq_state_t   state
);
  localparam int CNT_W = $clog2(DELAY_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DELAY_CYC - 1);

  seq_state_t   state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic         seen_q, seen_d;
  rst_targets_t tgt_q, tgt_d;
  logic         driving;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    seen_d  = seen_q;
    tgt_d   = tgt_q;
    unique case (state_q)
      SEQ_IDLE: begin
        if (accept) begin
          state_d = SEQ_DELAY;
          cnt_d   = '0;
          seen_d  = 1'b0;
          tgt_d   = targets;
        end
      end
      SEQ_DELAY: begin
        seen_d = seen_q | ~pin_sync;
        cnt_d  = cnt_q + 1'b1;
        if (cnt_q == CNT_LAST)
          state_d = (seen_q | ~pin_sync) ? SEQ_RELEASE : SEQ_STALL;
      end
      SEQ_STALL: begin
        if (!pin_sync) state_d = SEQ_RELEASE;
      end
      SEQ_RELEASE: begin
        if (pin_sync) state_d = SEQ_IDLE;
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      seen_q  <= 1'b0;
      tgt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      seen_q  <= seen_d;
      tgt_q   <= tgt_d;
    end
  end

  assign driving      = (state_q == SEQ_DELAY) || (state_q == SEQ_STALL);
  assign pin_pull_low = driving;
  assign core_rst     = driving && tgt_q.core;
  assign periph_rst   = driving && tgt_q.periph;
  assign busy         = (state_q != SEQ_IDLE);
  assign state        = state_q;
endmodule

// File: rtl/key_reset_ctrl.sv
module key_reset_ctrl
  import rstc_pkg::*;
#(
  parameter int DELAY_CYC   = 64,
  parameter int SYNC_STAGES = 2,
  parameter int GRP_W       = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        core_rst,
  output logic        periph_rst,
  output logic        pin_pull_low,
  input  logic        pin_level
);
  logic             seq_busy;
  logic             accept;
  rst_targets_t     targets;
  logic [GRP_W-1:0] cfg_grp;
  logic             pin_sync;
  seq_state_t       seq_state;

  rstc_regs #(.GRP_W(GRP_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .busy      (seq_busy),
    .reg_rdata (reg_rdata),
    .accept    (accept),
    .targets   (targets),
    .grp       (cfg_grp)
  );

  rstc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_level),
    .q     (pin_sync)
  );

  rstc_seq #(.DELAY_CYC(DELAY_CYC)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept       (accept),
    .targets      (targets),
    .pin_sync     (pin_sync),
    .busy         (seq_busy),
    .core_rst     (core_rst),
    .periph_rst   (periph_rst),
    .pin_pull_low (pin_pull_low),
    .state        (seq_state)
  );
endmodule

// File: rtl/rstc_checker.sv
module rstc_checker
  import rstc_pkg::*;
#(
  parameter int GRP_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [31:0]      reg_wdata,
  input logic             core_rst,
  input logic             periph_rst,
  input logic             pin_pull_low,
  input logic             seq_busy,
  input logic             accept,
  input logic [GRP_W-1:0] cfg_grp,
  input logic             pin_sync,
  input seq_state_t       seq_state
);
  assert_pull_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pin_pull_low) |-> $past(accept));

  assert_bad_key_no_effect_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_wdata[31:16] != UNLOCK_KEY) |=> ($stable(cfg_grp) && !$rose(pin_pull_low)));

  assert_pull_within_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pin_pull_low |-> seq_busy);

  assert_busy_end_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(seq_busy) |-> !pin_pull_low);

  assert_resets_with_pull_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rst || periph_rst) |-> pin_pull_low);

  assert_stall_keeps_pull_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == SEQ_STALL && pin_sync) |=> pin_pull_low);

  assert_busy_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_busy && reg_wr) |=> $stable(cfg_grp));
endmodule

bind key_reset_ctrl rstc_checker #(.GRP_W(GRP_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_wr       (reg_wr),
  .reg_wdata    (reg_wdata),
  .core_rst     (core_rst),
  .periph_rst   (periph_rst),
  .pin_pull_low (pin_pull_low),
  .seq_busy     (seq_busy),
  .accept       (accept),
  .cfg_grp      (cfg_grp),
  .pin_sync     (pin_sync),
  .seq_state    (seq_state)
);

// File: tb/tb_key_reset_ctrl.sv
`timescale 1ns/1ps
module tb_key_reset_ctrl;
  localparam int DLY = 12;
  localparam logic [31:0] KEY = 32'h05FA_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic        reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        core_rst, periph_rst, pin_pull_low, pin_level;
  logic        stuck_high;

  always #4 clk = ~clk;

  assign pin_level = stuck_high ? 1'b1 : ~pin_pull_low;

  key_reset_ctrl #(.DELAY_CYC(DLY)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_rst(core_rst),
    .periph_rst(periph_rst), .pin_pull_low(pin_pull_low), .pin_level(pin_level)
  );

  typedef struct {
    bit    core;
    bit    periph;
    int    len;
    bit    exact;
    string req;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;
  int   plen = 0;
  bit   pc = 0, pp = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_pulse(input bit c, input bit p, input int len, input bit exact, input string req);
    exp_t e;
    e.core = c; e.periph = p; e.len = len; e.exact = exact; e.req = req;
    q.push_back(e);
  endtask

  // monitor: measure each pull window and compare with the scoreboard
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (pin_pull_low) begin
        plen++;
        pc = pc | core_rst;
        pp = pp | periph_rst;
      end else if (plen > 0) begin
        if (q.size() == 0) begin
          check(0, "R1 unexpected pulse", plen, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(pc == e.core,   {e.req, " core"},   int'(pc), int'(e.core));
          check(pp == e.periph, {e.req, " periph"}, int'(pp), int'(e.periph));
          if (e.exact) check(plen == e.len, {e.req, " R7 length"}, plen, e.len);
          else         check(plen >= e.len, {e.req, " R8 length"}, plen, e.len);
        end
        plen = 0; pc = 0; pp = 0;
      end
    end
  end

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    reg_addr = 1'b0; reg_wr = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic a, output logic [31:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      rd(1'b1, v);
      if (!v[0]) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 1'b0; reg_wdata = '0; stuck_high = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    rd(1'b0, v); check(v == 32'h0, "R10 control", v, 0);
    rd(1'b1, v); check(v == 32'h0, "R10 status", v, 0);
    check({core_rst, periph_rst, pin_pull_low} == 3'b000, "R10 outputs",
          {core_rst, periph_rst, pin_pull_low}, 0);

    // R3 grouping write, no request; R4 key and request bits read 0
    wr(KEY | 32'h0000_0500);
    rd(1'b0, v); check(v == 32'h0000_0500, "R3 R4 readback", v, 32'h500);
    repeat (4) @(negedge clk);
    check(pin_pull_low == 1'b0, "R3 no request no pulse", pin_pull_low, 0);

    // R2 wrong key
    wr(32'h05FB_0204);
    repeat (6) @(negedge clk);
    check(pin_pull_low == 1'b0, "R2 no pulse", pin_pull_low, 0);
    rd(1'b0, v); check(v == 32'h0000_0500, "R2 group kept", v, 32'h500);

    // R1 system request, grouping written back unchanged
    expect_pulse(1, 1, DLY, 1, "R1");
    wr(KEY | 32'h0000_0504);
    rd(1'b1, v); check(v == 32'h1, "R6 busy set", v, 1);
    rd(1'b0, v); check(v == 32'h0000_0500, "R3 R4 during request", v, 32'h500);
    wait_idle();
    rd(1'b1, v); check(v == 32'h0, "R6 busy cleared", v, 0);

    // R5 single and combined targets
    expect_pulse(1, 0, DLY, 1, "R5 core");
    wr(KEY | 32'h0000_0501);
    wait_idle();
    expect_pulse(0, 1, DLY, 1, "R5 periph");
    wr(KEY | 32'h0000_0502);
    wait_idle();
    expect_pulse(0, 0, DLY, 1, "R5 pin");
    wr(KEY | 32'h0000_0508);
    wait_idle();
    expect_pulse(1, 1, DLY, 1, "R5 combo");
    wr(KEY | 32'h0000_050B);
    wait_idle();

    // R9 write while busy ignored
    expect_pulse(1, 0, DLY, 1, "R9");
    wr(KEY | 32'h0000_0501);
    wr(KEY | 32'h0000_0702);
    wait_idle();
    rd(1'b0, v); check(v == 32'h0000_0500, "R9 group kept", v, 32'h500);

    // R8 line held high by the board
    stuck_high = 1'b1;
    expect_pulse(1, 1, DLY + 20, 0, "R8");
    wr(KEY | 32'h0000_0504);
    repeat (DLY + 20) @(negedge clk);
    rd(1'b1, v); check(v == 32'h1, "R8 still busy", v, 1);
    check(pin_pull_low == 1'b1, "R8 still pulling", pin_pull_low, 1);
    check(core_rst == 1'b1, "R8 core held", core_rst, 1);
    stuck_high = 1'b0;
    wait_idle();
    rd(1'b1, v); check(v == 32'h0, "R8 completes", v, 0);

    check(q.size() == 0, "R7 scoreboard drained", q.size(), 0);
    done = 1;
    summary();
    $finish;
  end
endmodule